// File: doc/BRIEF.md
# Segment Row Latch with View Modifiers

This block holds one row of segment gray levels for the segment drivers of a dot-matrix display. Once per common period a line strobe rises. At that moment the block copies the row currently read from display memory into an output register and applies the view controls on the way in. The controls are display enable, force-all-lit and inversion. Display memory itself is never rewritten to get these effects. The output row stays fixed for the whole common period, so host traffic to display memory and changes on the control pins have no effect partway through a row.

The line strobe is sampled in the system clock domain. A rising edge is found by comparing the strobe with its value one cycle earlier. The controls are evaluated in the same cycle as the row capture. Each segment is a gray code of `GW` bits, so a row is `NSEG*GW` bits wide.

Top module: `row_view_latch`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `seg_out` becomes all zeros. It stays zero until the first line strobe edge after reset.
- R2: A line strobe edge is a `clk` edge at which `line_clk` is sampled high after being sampled low at the previous edge. At that edge `seg_out` takes the modified copy of `ram_row`, and the new value is visible right after that edge.
- R3: At every other `clk` edge `seg_out` keeps its value. This holds while `line_clk` stays high, when it falls, and when `ram_row` changes.
- R4: Segment k occupies bits `[GW*k+GW-1 : GW*k]` of both `ram_row` and `seg_out`. With `disp_on`=1, `all_on`=0 and `reverse`=0, each output segment equals its input segment.
- R5: With `disp_on`=1, `all_on`=0 and `reverse`=1, each output segment equals `2**GW-1` minus its input gray value, so 0 maps to 15 and 15 maps to 0 for `GW`=4.
- R6: With `disp_on`=0, every output segment is 0, whatever `all_on`, `reverse` and `ram_row` are.
- R7: With `disp_on`=1 and `all_on`=1, every output segment is `2**GW-1`, whatever `reverse` and `ram_row` are.
- R8: A change of `disp_on`, `all_on` or `reverse` between strobe edges has no effect on `seg_out` until the next strobe edge. At that edge the control values sampled in the same cycle apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk | input | 1 | Line strobe; its rising edge starts a common period |
| ram_row | input | NSEG*GW | Row of gray codes read from display memory |
| disp_on | input | 1 | Display enable; 0 blanks the row |
| all_on | input | 1 | Force every segment to full level |
| reverse | input | 1 | Invert every gray level |
| seg_out | output | NSEG*GW | Latched, modified row for the segment drivers |

## Verification
A capture takes exactly one register stage. When `line_clk` is driven high between edges, the row and controls present then appear on `seg_out` just after the next `clk` rising edge. The bench drives all inputs on the falling edge and reads `seg_out` on the following falling edge, half a cycle after the capturing edge. To confirm that the row is held, the bench changes the row and controls while the strobe stays high or low, then reads again one full cycle later. A reset result is read on the falling edge after the first reset edge.

// File: rtl/row_view_pkg.sv
package row_view_pkg;

  // Effective view applied to a captured row, already resolved by precedence
  typedef enum logic [1:0] {
    VIEW_NORMAL  = 2'd0,
    VIEW_INVERT  = 2'd1,
    VIEW_BLANK   = 2'd2,
    VIEW_FULL    = 2'd3
  } view_mode_e;

endpackage

// File: rtl/line_edge_det.sv
module line_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic line_clk,
  output logic load
);

  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= line_clk;
  end

  assign load = line_clk & ~line_q;

endmodule

// File: rtl/view_mode_sel.sv
module view_mode_sel
  import row_view_pkg::*;
(
  input  logic       disp_on,
  input  logic       all_on,
  input  logic       reverse,
  output view_mode_e mode
);

  // blanking beats forced-on, which beats inversion
  always_comb begin
    if (!disp_on)     mode = VIEW_BLANK;
    else if (all_on)  mode = VIEW_FULL;
    else if (reverse) mode = VIEW_INVERT;
    else              mode = VIEW_NORMAL;
  end

endmodule

// File: rtl/seg_view_cell.sv
module seg_view_cell
  import row_view_pkg::*;
#(
  parameter int GW = 4
) (
  input  view_mode_e    mode,
  input  logic [GW-1:0] gin,
  output logic [GW-1:0] gout
);

  localparam logic [GW-1:0] GMAX = '1;

  always_comb begin
    unique case (mode)
      VIEW_BLANK:  gout = '0;
      VIEW_FULL:   gout = GMAX;
      VIEW_INVERT: gout = GMAX - gin;
      default:     gout = gin;
    endcase
  end

endmodule

// File: rtl/row_view_latch.sv
module row_view_latch
  import row_view_pkg::*;
#(
  parameter int NSEG = 160,
  parameter int GW   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_clk,
  input  logic [NSEG*GW-1:0]   ram_row,
  input  logic                 disp_on,
  input  logic                 all_on,
  input  logic                 reverse,
  output logic [NSEG*GW-1:0]   seg_out
);

  localparam int ROWW = NSEG * GW;

  logic            load;
  view_mode_e      mode;
  logic [ROWW-1:0] row_next;

  line_edge_det u_edge (
    .clk      (clk),
    .rst      (rst),
    .line_clk (line_clk),
    .load     (load)
  );

  view_mode_sel u_mode (
    .disp_on (disp_on),
    .all_on  (all_on),
    .reverse (reverse),
    .mode    (mode)
  );

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    seg_view_cell #(.GW(GW)) u_cell (
      .mode (mode),
      .gin  (ram_row[k*GW +: GW]),
      .gout (row_next[k*GW +: GW])
    );
  end

  // one register: controls and row are taken together at the strobe edge
  always_ff @(posedge clk) begin
    if (rst)       seg_out <= '0;
    else if (load) seg_out <= row_next;
  end

endmodule

// File: rtl/row_view_chk.sv
module row_view_chk #(
  parameter int NSEG = 160,
  parameter int GW   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               line_clk,
  input logic [NSEG*GW-1:0] ram_row,
  input logic               disp_on,
  input logic               all_on,
  input logic               reverse,
  input logic [NSEG*GW-1:0] seg_out
);

  logic prev_line;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) prev_line <= 1'b0;
    else     prev_line <= line_clk;
  end

  assign rise = line_clk && !prev_line;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> seg_out == '0);

  // R3
  hold_row_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(seg_out));

  // R4
  normal_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && disp_on && !all_on && !reverse) |=> seg_out == $past(ram_row));

  // R5
  invert_row_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && disp_on && !all_on && reverse) |=> seg_out == ~$past(ram_row));

  // R6
  blank_row_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && !disp_on) |=> seg_out == '0);

  // R7
  full_row_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && disp_on && all_on) |=> seg_out == '1);

endmodule

bind row_view_latch row_view_chk #(.NSEG(NSEG), .GW(GW)) u_chk (.*);

// File: tb/sim_row_view_latch.sv
module sim_row_view_latch;

  localparam int NSEG = 160;
  localparam int GW   = 4;
  localparam int ROWW = NSEG * GW;

  logic            clk = 1'b0;
  logic            rst;
  logic            line_clk;
  logic [ROWW-1:0] ram_row;
  logic            disp_on, all_on, reverse;
  logic [ROWW-1:0] seg_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  row_view_latch #(.NSEG(NSEG), .GW(GW)) u0 (
    .clk(clk), .rst(rst), .line_clk(line_clk), .ram_row(ram_row),
    .disp_on(disp_on), .all_on(all_on), .reverse(reverse), .seg_out(seg_out)
  );

  function automatic logic [ROWW-1:0] model(input logic [ROWW-1:0] r,
                                            input logic d, input logic a,
                                            input logic v);
    logic [ROWW-1:0] o;
    for (int k = 0; k < NSEG; k++) begin
      logic [GW-1:0] g;
      g = r[k*GW +: GW];
      if (!d)     o[k*GW +: GW] = '0;
      else if (a) o[k*GW +: GW] = {GW{1'b1}};
      else if (v) o[k*GW +: GW] = 4'd15 - g;
      else        o[k*GW +: GW] = g;
    end
    return o;
  endfunction

  function automatic logic [ROWW-1:0] rand_row();
    logic [ROWW-1:0] r;
    for (int i = 0; i < ROWW / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input string req, input logic [ROWW-1:0] exp);
    checks++;
    if (seg_out !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, seg_out, exp);
    end
  endtask

  // strobe a row in, check the capture, then disturb inputs and check the hold
  task automatic strobe(input string req, input logic [ROWW-1:0] r,
                        input logic d, input logic a, input logic v);
    logic [ROWW-1:0] exp;
    exp = model(r, d, a, v);
    ram_row = r; disp_on = d; all_on = a; reverse = v; line_clk = 1'b1;
    @(negedge clk);
    check(req, exp);
    ram_row = rand_row();
    {disp_on, all_on, reverse} = 3'($urandom);
    @(negedge clk);
    check("R3 hold while strobe high", exp);
    line_clk = 1'b0;
    ram_row = rand_row();
    {disp_on, all_on, reverse} = 3'($urandom);
    @(negedge clk);
    check("R8 held after strobe falls", exp);
  endtask

  initial begin
    logic [ROWW-1:0] r;
    void'($urandom(32'h5eed_0101));
    rst = 1'b1; line_clk = 1'b0; ram_row = '1;
    disp_on = 1'b1; all_on = 1'b0; reverse = 1'b0;
    @(negedge clk);
    check("R1 reset clears row", '0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 zero until first strobe", '0);

    r = rand_row();
    strobe("R2 R4 normal capture", r, 1'b1, 1'b0, 1'b0);
    strobe("R5 invert zeros", '0, 1'b1, 1'b0, 1'b1);
    strobe("R5 invert fulls", '1, 1'b1, 1'b0, 1'b1);
    strobe("R5 invert random", rand_row(), 1'b1, 1'b0, 1'b1);
    strobe("R6 blank beats all-on and invert", '1, 1'b0, 1'b1, 1'b1);
    strobe("R7 full beats invert", '1, 1'b1, 1'b1, 1'b1);
    strobe("R7 full from zeros", '0, 1'b1, 1'b1, 1'b0);

    // long idle with changing controls: output must not move
    r = seg_out;
    for (int i = 0; i < 6; i++) begin
      {disp_on, all_on, reverse} = 3'(i);
      ram_row = rand_row();
      @(negedge clk);
      check("R8 controls ignored between strobes", r);
    end

    for (int n = 0; n < 300; n++) begin
      logic [2:0] c;
      c = 3'($urandom);
      strobe("R2 random capture", rand_row(), c[2], c[1], c[0]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule